// File: doc/BRIEF.md
# Masked Event Interrupt Controller

This block gathers status events from a network controller into one latched event register. The transmit engine, the receive engine and other sources raise events with single-cycle pulses. Two events come from the register port itself: the management-done event and the graceful-stop-complete event. Software reads the latched events, clears the ones it has handled by writing ones to them, and chooses which events may interrupt by writing a 32-bit mask register.

The block drives thirteen separate interrupt lines. Each line belongs to exactly one event bit and follows a fixed, permuted line order. A line is high while its event bit and the matching mask bit are both set. The lines come from flip-flops, so each one follows the register state one clock later. A controller reset input clears the event and mask registers without using the asynchronous reset.

Top module: `evt_irq_ctrl`

## Requirements
- R1: The event register holds only bits 31..19: 31 heartbeat, 30 babbling receive, 29 babbling transmit, 28 graceful stop done, 27 transmit frame, 26 transmit buffer, 25 receive frame, 24 receive buffer, 23 management done, 22 bus error, 21 late collision, 20 retry limit, 19 underrun. A one on `raise_i[b]` sets event bit b at the next edge for b in 31..19. Raise bits 18..0 are ignored, and event bits 18..0 always read 0.
- R2: A write to address 1 (event register) clears every event bit whose `wdata` bit is 1 and leaves all other event bits unchanged.
- R3: If a raise pulse and a write-one-to-clear hit the same event bit in the same cycle, the bit ends up set.
- R4: A write to address 2 (mask register) replaces all 32 mask bits with `wdata`.
- R5: Interrupt lines 0 to 12 take their events from bits 27, 26, 19, 20, 25, 24, 23, 21, 31, 28, 22, 29, 30 in that order. Each line is the AND of its event bit and the mask bit at the same position.
- R6: The interrupt lines are registered. A change to the event or mask register made at edge k appears on `irq_o` at edge k+1.
- R7: Any write to address 3 (management frame register) sets event bit 23, whatever the data.
- R8: A write to address 4 (transmit control) with `wdata[0]`=1 sets event bit 28. With `wdata[0]`=0 it has no effect on the events.
- R9: `ctrl_rst` high at an edge clears both the event and mask registers. It overrides any raise or write in the same cycle.
- R10: With `rd_en` high at an edge, `rdata` shows the event register for address 1 and the mask register for address 2. The value shown is the one before that edge's update, and it is valid after the edge. Any other address, or no read, gives 0.
- R11: While `rst_n` is low, the event register, mask register, `rdata` and `irq_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_rst | input | 1 | Synchronous controller reset of events and mask |
| raise_i | input | 32 | Event set pulses, one per event bit position |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq_o | output | 13 | Interrupt lines in the fixed line order |

## Verification
A wrong event or mask bit shows on `rdata` one cycle after the next read of that register. If the matching bit in the other register is set, it also shows on its interrupt line one edge after the state goes wrong. A mapping error shows up as the wrong line rising when a single event bit is raised with the full mask enabled. The reference model tracks both registers every cycle and compares every line and every read, so any divergence in reachable state is reported within a cycle of it becoming visible.

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl #(
  parameter int AW     = 3,
  parameter int DW     = 32,
  parameter int NLINE  = 13,
  parameter int EVT_LO = 19
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctrl_rst,
  input  logic [DW-1:0] raise_i,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic [NLINE-1:0] irq_o
);

  localparam logic [AW-1:0] A_EVT  = AW'(1);
  localparam logic [AW-1:0] A_MASK = AW'(2);
  localparam logic [AW-1:0] A_MGMT = AW'(3);
  localparam logic [AW-1:0] A_TXC  = AW'(4);
  localparam int B_MGMT = 23;
  localparam int B_GSTP = 28;
  localparam logic [DW-1:0] EVT_KEEP = {{(DW-EVT_LO){1'b1}}, {EVT_LO{1'b0}}};

  function automatic int line_src(input int i);
    case (i)
      0:  return 27;
      1:  return 26;
      2:  return 19;
      3:  return 20;
      4:  return 25;
      5:  return 24;
      6:  return 23;
      7:  return 21;
      8:  return 31;
      9:  return 28;
      10: return 22;
      11: return 29;
      default: return 30;
    endcase
  endfunction

  logic [DW-1:0] evt_q, mask_q, evt_d, set_v, clr_v, active;

  wire wr_evt  = wr_en && (addr == A_EVT);
  wire wr_mask = wr_en && (addr == A_MASK);
  wire wr_mgmt = wr_en && (addr == A_MGMT);
  wire wr_gstp = wr_en && (addr == A_TXC) && wdata[0];

  assign set_v  = (raise_i & EVT_KEEP)
                | (DW'(wr_mgmt) << B_MGMT)
                | (DW'(wr_gstp) << B_GSTP);
  assign clr_v  = wr_evt ? wdata : '0;
  assign evt_d  = ((evt_q & ~clr_v) | set_v) & EVT_KEEP;
  assign active = evt_q & mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q  <= '0;
      mask_q <= '0;
    end else if (ctrl_rst) begin
      evt_q  <= '0;
      mask_q <= '0;
    end else begin
      evt_q <= evt_d;
      if (wr_mask) mask_q <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      rdata <= '0;
    else if (rd_en && addr == A_EVT)  rdata <= evt_q;
    else if (rd_en && addr == A_MASK) rdata <= mask_q;
    else                             rdata <= '0;
  end

  for (genvar gi = 0; gi < NLINE; gi++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_o[gi] <= 1'b0;
      else        irq_o[gi] <= active[line_src(gi)];
    end
  end

endmodule

// File: rtl/evt_irq_ctrl_chk.sv
module evt_irq_ctrl_chk #(
  parameter int AW    = 3,
  parameter int DW    = 32,
  parameter int NLINE = 13
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ctrl_rst,
  input logic [DW-1:0] raise_i,
  input logic          wr_en,
  input logic          rd_en,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] wdata,
  input logic [DW-1:0] rdata,
  input logic [DW-1:0] evt_q,
  input logic [DW-1:0] mask_q,
  input logic [NLINE-1:0] irq_o
);

  p_w1c_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(1) && !ctrl_rst) |=> ((evt_q & $past(wdata & ~raise_i)) == '0));

  p_set_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_rst && raise_i[31:19] != '0) |=>
      ((evt_q[31:19] & $past(raise_i[31:19])) == $past(raise_i[31:19])));

  p_mask_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(2) && !ctrl_rst) |=> (mask_q == $past(wdata)));

  p_map_hb_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o[8]) |-> $past(evt_q[31] && mask_q[31]));

  p_map_txf_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o[0]) |-> $past(evt_q[27] && mask_q[27]));

  p_mgmt_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(3) && !ctrl_rst) |=> evt_q[23]);

  p_gstop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(4) && wdata[0] && !ctrl_rst) |=> evt_q[28]);

  p_ctrl_rst_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_rst |=> (evt_q == '0 && mask_q == '0));

  p_idle_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rd_en) |-> (rdata == '0));

endmodule

bind evt_irq_ctrl evt_irq_ctrl_chk #(.AW(AW), .DW(DW), .NLINE(NLINE)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl_rst(ctrl_rst), .raise_i(raise_i),
  .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata),
  .evt_q(evt_q), .mask_q(mask_q), .irq_o(irq_o)
);

// File: tb/evt_irq_ctrl_tb.sv
`timescale 1ns/1ps
module evt_irq_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctrl_rst = 1'b0;
  logic [31:0] raise_i = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [12:0] irq_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  evt_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .ctrl_rst(ctrl_rst), .raise_i(raise_i),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq_o(irq_o)
  );

  int lmap [13] = '{27, 26, 19, 20, 25, 24, 23, 21, 31, 28, 22, 29, 30};
  logic [31:0] m_evt = '0, m_mask = '0, m_rdata = '0;
  logic [12:0] m_irq = '0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_evt = '0; m_mask = '0; m_rdata = '0; m_irq = '0;
    end else begin
      logic [31:0] act, nxt;
      act = m_evt & m_mask;
      for (int i = 0; i < 13; i++) m_irq[i] = act[lmap[i]];
      if (rd_en && addr == 3'd1)      m_rdata = m_evt;
      else if (rd_en && addr == 3'd2) m_rdata = m_mask;
      else                            m_rdata = '0;
      if (ctrl_rst) begin
        m_evt = '0; m_mask = '0;
      end else begin
        nxt = m_evt;
        if (wr_en && addr == 3'd1) nxt = nxt & ~wdata;
        for (int b = 19; b < 32; b++) if (raise_i[b]) nxt[b] = 1'b1;
        if (wr_en && addr == 3'd3) nxt[23] = 1'b1;
        if (wr_en && addr == 3'd4 && wdata[0]) nxt[28] = 1'b1;
        m_evt = nxt;
        if (wr_en && addr == 3'd2) m_mask = wdata;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R5 irq lines", {19'd0, irq_o}, {19'd0, m_irq});
      chk("R10 read data", rdata, m_rdata);
    end
  end

  task automatic cyc(input logic [31:0] rs, input logic w, input logic r,
                     input logic [2:0] a, input logic [31:0] d, input logic cr);
    raise_i = rs; wr_en = w; rd_en = r; addr = a; wdata = d; ctrl_rst = cr;
    @(posedge clk); #1;
    raise_i = '0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0; ctrl_rst = 1'b0;
  endtask

  task automatic rd_expect(input logic [2:0] a, input logic [31:0] exp, input string tag);
    cyc('0, 1'b0, 1'b1, a, '0, 1'b0);
    @(negedge clk);
    chk(tag, rdata, exp);
    @(posedge clk); #1;
  endtask

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R11 rdata in reset", rdata, '0);
    chk("R11 irq in reset", {19'd0, irq_o}, '0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(posedge clk); #1;
    rd_expect(3'd1, 32'h0, "R11 event after reset");
    rd_expect(3'd2, 32'h0, "R11 mask after reset");

    cyc(32'hFFFF_FFFF, 0, 0, 0, 0, 0);
    rd_expect(3'd1, 32'hFFF8_0000, "R1 raise all");
    cyc(0, 1, 0, 3'd1, 32'h0F00_0000, 0);
    rd_expect(3'd1, 32'hF0F8_0000, "R2 w1c partial");
    cyc(32'h8000_0000, 1, 0, 3'd1, 32'hC000_0000, 0);
    rd_expect(3'd1, 32'hB0F8_0000, "R3 set beats clear");

    cyc(0, 1, 0, 3'd2, 32'hFFFF_FFFF, 0);
    @(negedge clk);
    chk("R6 irq lags mask", {19'd0, irq_o}, '0);
    @(posedge clk); #1;
    @(negedge clk);
    chk("R5 line map", {19'd0, irq_o}, 32'h0000_0FCC);
    @(posedge clk); #1;
    rd_expect(3'd2, 32'hFFFF_FFFF, "R4 mask readback");

    cyc(0, 1, 0, 3'd1, 32'hFFFF_FFFF, 0);
    rd_expect(3'd1, 32'h0, "R2 clear all");
    cyc(0, 1, 0, 3'd3, 32'h0, 0);
    rd_expect(3'd1, 32'h0080_0000, "R7 mgmt write");
    cyc(0, 1, 0, 3'd4, 32'hFFFF_FFFE, 0);
    rd_expect(3'd1, 32'h0080_0000, "R8 tx ctrl bit0 clear");
    cyc(0, 1, 0, 3'd4, 32'h1, 0);
    rd_expect(3'd1, 32'h1080_0000, "R8 tx ctrl bit0 set");

    cyc(32'hFFFF_FFFF, 1, 0, 3'd2, 32'h1234_5678, 1);
    rd_expect(3'd1, 32'h0, "R9 ctrl reset event");
    rd_expect(3'd2, 32'h0, "R9 ctrl reset mask");

    cyc(32'h0007_FFFF, 0, 0, 0, 0, 0);
    rd_expect(3'd1, 32'h0, "R1 low raise ignored");
    cyc(0, 1, 0, 3'd2, 32'hFFFF_FFFF, 0);
    cyc(32'h0800_0000, 0, 0, 0, 0, 0);
    @(negedge clk);
    chk("R6 irq lags event", {19'd0, irq_o}, '0);
    @(posedge clk); #1;
    @(negedge clk);
    chk("R5 transmit frame line", {19'd0, irq_o}, 32'h1);
    @(posedge clk); #1;
    rd_expect(3'd5, 32'h0, "R10 unused address");

    for (int n = 0; n < 3000; n++) begin
      logic [31:0] rs;
      rs = $urandom & $urandom & $urandom;
      cyc(rs, ($urandom % 3) == 0, ($urandom % 2) == 0, 3'($urandom % 6),
          $urandom & $urandom, ($urandom % 64) == 0);
    end

    @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule